// File: doc/BRIEF.md
# Serial EEPROM Transaction Sequencer

This block is an SPI master that runs one complete serial-EEPROM transaction for each request it accepts. A request names one of four command kinds, a 24-bit address and a byte count. The block then builds a frame out of whole bytes and shifts it out with chip select held low from start to finish. The frame is the opcode, then the address for memory commands, then a data phase. In the data phase, write bytes are pulled from the requester through a ready/valid handshake. For read and status commands the block sends filler bytes of all ones and captures the slave's reply bytes.

Each received byte is presented with a one-cycle valid strobe. When chip select is released, a one-cycle done pulse marks the end of the frame. A busy flag covers the whole transaction, and requests are taken only while the block is idle. The serial clock comes from the system clock through a parameterised half-period divider. The bus runs in SPI mode 0.

Top module: `spi_eeprom_seq`

## Requirements
- R1: After reset, csN is 1, sclk is 0, and busy, done, rdValid and wrReady are all 0.
- R2: The first byte of every frame is the opcode for reqKind: 0 (status) sends 0x05, 1 (write enable) sends 0x06, 2 (write) sends 0x02 and 3 (read) sends 0x03.
- R3: For reqKind 2 and 3, the opcode is followed by the three bytes of reqAddr, bits 23:16 first. Every byte on mosi is sent bit 7 first.
- R4: A frame has exactly 8 rising sclk edges per byte. That is 8·(1+reqLen) for status, 8 for write enable (reqLen is ignored) and 8·(4+reqLen) for read and write.
- R5: csN falls once when a request is accepted and rises once at the end of the frame. sclk stays 0 whenever csN is 1.
- R6: During the data phase of status and read frames, mosi sends filler bytes of 0xFF.
- R7: miso is sampled on rising sclk edges. Each data-phase byte of a status or read frame appears on rdData with a one-cycle rdValid pulse, reqLen bytes in total. No rdValid is produced for header bytes, write frames or write-enable frames.
- R8: In a write frame, wrReady is high while the block waits for the next data byte, and the byte is taken when wrValid and wrReady are both high. While waiting, sclk stays 0 and csN stays 0.
- R9: mosi changes only while sclk is low and stays stable through every high phase of sclk.
- R10: At least HALF_DIV system clocks pass between the fall of csN and the first rising sclk edge. At least HALF_DIV clocks also pass between the last falling sclk edge and the rise of csN.
- R11: busy goes high on the cycle after acceptance and stays high until done pulses for one cycle, as csN rises. reqValid has no effect while busy is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request strobe, taken only while idle |
| reqKind | input | 2 | Command kind: 0 status, 1 write enable, 2 write, 3 read |
| reqAddr | input | ADDR_W | Memory address for read and write |
| reqLen | input | LEN_W | Number of data bytes |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle pulse at the end of a transaction |
| wrData | input | 8 | Write data byte |
| wrValid | input | 1 | Write data byte offered |
| wrReady | output | 1 | Block is waiting for a write data byte |
| rdData | output | 8 | Received data byte |
| rdValid | output | 1 | rdData holds a new byte |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to the slave |
| miso | input | 1 | Serial data from the slave |
| csN | output | 1 | Active-low chip select |

## Verification
csN and busy change on the clock edge that accepts a request. The first rising sclk edge comes 2·HALF_DIV clocks later, and each later half period of sclk lasts HALF_DIV clocks, apart from pauses for write data. rdValid rises on the edge where sclk falls after a received byte's eighth bit. done comes HALF_DIV clocks after the last falling edge. The bench does not predict these cycle numbers. It samples every output on the falling system clock edge, rebuilds the mosi bytes at each observed sclk rise, and compares the whole frame, the edge counts, the gaps and the received bytes only after done has been seen. The miso model changes its bit on sclk falls, so the value is settled before each rise.

// File: rtl/spi_eeprom_pkg.sv
package spi_eeprom_pkg;

  typedef enum logic [1:0] {
    K_STATUS = 2'd0,
    K_WREN   = 2'd1,
    K_WRITE  = 2'd2,
    K_READ   = 2'd3
  } cmdKind_t;

  typedef enum logic [1:0] {
    SRC_OP   = 2'd0,
    SRC_ADDR = 2'd1,
    SRC_WR   = 2'd2,
    SRC_FILL = 2'd3
  } byteSrc_t;

  // strobes from the control to the datapath
  typedef struct packed {
    logic     latchReq;
    logic     loadTx;
    byteSrc_t src;
    logic [2:0] hdrSel;   // 1..N selects address byte, most significant first
    cmdKind_t opKind;
    logic     divEn;
    logic     shiftEn;
    logic     captureRx;
  } dpCtl_t;

  localparam logic [7:0] FILL_BYTE = 8'hFF;

  function automatic logic [7:0] opcodeOf(cmdKind_t k);
    logic [7:0] op;
    case (k)
      K_STATUS: op = 8'h05;
      K_WREN:   op = 8'h06;
      K_WRITE:  op = 8'h02;
      default:  op = 8'h03;
    endcase
    return op;
  endfunction

endpackage

// File: rtl/spi_eeprom_dp.sv
module spi_eeprom_dp
  import spi_eeprom_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int ADDR_W   = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [7:0]        wrData,
  input  logic              miso,
  output logic              halfTick,
  output logic              byteEnd,
  output logic              sclk,
  output logic              mosi,
  output logic [7:0]        rdData,
  output logic              rdValid
);

  localparam int ADDR_BYTES = ADDR_W / 8;
  localparam int DIV_W      = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);

  logic [DIV_W-1:0]  divCnt;
  logic [ADDR_W-1:0] addrQ;
  logic [7:0]        txSh;
  logic [7:0]        rxSh;
  logic [2:0]        bitCnt;
  logic [7:0]        addrByte;
  logic [7:0]        nextByte;

  // half-period divider
  assign halfTick = ctl.divEn && (divCnt == DIV_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        divCnt <= '0;
    else if (!ctl.divEn || halfTick)  divCnt <= '0;
    else                              divCnt <= divCnt + 1'b1;
  end

  // byte ends on the falling half-tick after bit 7
  assign byteEnd = ctl.shiftEn && halfTick && sclk && (bitCnt == 3'd7);

  // address byte picked by header index, most significant byte first
  always_comb begin
    addrByte = '0;
    for (int i = 0; i < ADDR_BYTES; i++) begin
      if (int'(ctl.hdrSel) == i + 1) addrByte = addrQ[8*(ADDR_BYTES-1-i) +: 8];
    end
  end

  always_comb begin
    case (ctl.src)
      SRC_OP:   nextByte = opcodeOf(ctl.opKind);
      SRC_ADDR: nextByte = addrByte;
      SRC_WR:   nextByte = wrData;
      default:  nextByte = FILL_BYTE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) addrQ <= '0;
    else if (ctl.latchReq) addrQ <= reqAddr;
  end

  // transmit shifter: load on a byte boundary, shift on each falling half-tick
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSh   <= '0;
      bitCnt <= '0;
    end else if (ctl.loadTx) begin
      txSh   <= nextByte;
      bitCnt <= '0;
    end else if (ctl.shiftEn && halfTick && sclk && (bitCnt != 3'd7)) begin
      txSh   <= {txSh[6:0], 1'b0};
      bitCnt <= bitCnt + 3'd1;
    end
  end

  assign mosi = txSh[7];

  // mode 0 serial clock
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        sclk <= 1'b0;
    else if (!ctl.shiftEn)            sclk <= 1'b0;
    else if (halfTick)                sclk <= ~sclk;
  end

  // receive shifter samples on the rising half-tick
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxSh <= '0;
    else if (ctl.shiftEn && halfTick && !sclk) rxSh <= {rxSh[6:0], miso};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= ctl.captureRx;
      if (ctl.captureRx) rdData <= rxSh;
    end
  end

endmodule

// File: rtl/spi_eeprom_ctrl.sv
module spi_eeprom_ctrl
  import spi_eeprom_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int LEN_W  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  cmdKind_t         reqKind,
  input  logic [LEN_W-1:0] reqLen,
  input  logic             wrValid,
  input  logic             halfTick,
  input  logic             byteEnd,
  output dpCtl_t           ctl,
  output logic             wrReady,
  output logic             csN,
  output logic             busy,
  output logic             done
);

  localparam int ADDR_BYTES = ADDR_W / 8;
  localparam logic [2:0] HDR_ADDR_LAST = 3'(ADDR_BYTES);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_SHIFT, S_FETCH, S_HOLD} state_t;

  state_t           state;
  cmdKind_t         kindQ;
  logic [LEN_W-1:0] lenLeft;
  logic [2:0]       hdrIdx;
  logic             inData;

  logic accept, isWr, hasAddr, wantsRx, lastHdr, moreData;

  assign accept   = (state == S_IDLE) && reqValid;
  assign isWr     = (kindQ == K_WRITE);
  assign hasAddr  = (kindQ == K_WRITE) || (kindQ == K_READ);
  assign wantsRx  = (kindQ == K_READ) || (kindQ == K_STATUS);
  assign lastHdr  = inData || (hdrIdx == (hasAddr ? HDR_ADDR_LAST : 3'd0));
  assign moreData = (lenLeft != '0);

  always_comb begin
    ctl           = '0;
    ctl.src       = SRC_FILL;
    ctl.opKind    = reqKind;
    ctl.divEn     = (state == S_SETUP) || (state == S_SHIFT) || (state == S_HOLD);
    ctl.shiftEn   = (state == S_SHIFT);
    if (accept) begin
      ctl.latchReq = 1'b1;
      ctl.loadTx   = 1'b1;
      ctl.src      = SRC_OP;
    end
    if ((state == S_SHIFT) && byteEnd) begin
      ctl.captureRx = inData && wantsRx;
      if (!lastHdr) begin
        ctl.loadTx = 1'b1;
        ctl.src    = SRC_ADDR;
        ctl.hdrSel = hdrIdx + 3'd1;
      end else if (moreData && !isWr) begin
        ctl.loadTx = 1'b1;
        ctl.src    = SRC_FILL;
      end
    end
    if ((state == S_FETCH) && wrValid) begin
      ctl.loadTx = 1'b1;
      ctl.src    = SRC_WR;
    end
  end

  assign wrReady = (state == S_FETCH);
  assign busy    = (state != S_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      kindQ   <= K_STATUS;
      lenLeft <= '0;
      hdrIdx  <= '0;
      inData  <= 1'b0;
      csN     <= 1'b1;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (accept) begin
          state   <= S_SETUP;
          csN     <= 1'b0;
          kindQ   <= reqKind;
          lenLeft <= (reqKind == K_WREN) ? '0 : reqLen;
          hdrIdx  <= '0;
          inData  <= 1'b0;
        end
        S_SETUP: if (halfTick) state <= S_SHIFT;
        S_SHIFT: if (byteEnd) begin
          if (!lastHdr) begin
            hdrIdx <= hdrIdx + 3'd1;
          end else if (moreData) begin
            lenLeft <= lenLeft - 1'b1;
            inData  <= 1'b1;
            if (isWr) state <= S_FETCH;
          end else begin
            state <= S_HOLD;
          end
        end
        S_FETCH: if (wrValid) state <= S_SHIFT;
        S_HOLD: if (halfTick) begin
          state <= S_IDLE;
          csN   <= 1'b1;
          done  <= 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spi_eeprom_seq.sv
module spi_eeprom_seq
  import spi_eeprom_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int ADDR_W   = 24,
  parameter int LEN_W    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqKind,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  output logic              busy,
  output logic              done,
  input  logic [7:0]        wrData,
  input  logic              wrValid,
  output logic              wrReady,
  output logic [7:0]        rdData,
  output logic              rdValid,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              csN
);

  dpCtl_t ctl;
  logic   halfTick;
  logic   byteEnd;

  spi_eeprom_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqKind  (cmdKind_t'(reqKind)),
    .reqLen   (reqLen),
    .wrValid  (wrValid),
    .halfTick (halfTick),
    .byteEnd  (byteEnd),
    .ctl      (ctl),
    .wrReady  (wrReady),
    .csN      (csN),
    .busy     (busy),
    .done     (done)
  );

  spi_eeprom_dp #(.HALF_DIV(HALF_DIV), .ADDR_W(ADDR_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .reqAddr  (reqAddr),
    .wrData   (wrData),
    .miso     (miso),
    .halfTick (halfTick),
    .byteEnd  (byteEnd),
    .sclk     (sclk),
    .mosi     (mosi),
    .rdData   (rdData),
    .rdValid  (rdValid)
  );

endmodule

// File: rtl/spi_eeprom_seq_chk.sv
module spi_eeprom_seq_chk #(
  parameter int HALF_DIV = 2
) (
  input logic clk,
  input logic rstN,
  input logic busy,
  input logic done,
  input logic csN,
  input logic sclk,
  input logic mosi,
  input logic wrReady,
  input logic rdValid
);

  logic [15:0] sinceCs;
  logic        seenRise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinceCs  <= '0;
      seenRise <= 1'b0;
    end else if (csN) begin
      sinceCs  <= '0;
      seenRise <= 1'b0;
    end else begin
      if (sinceCs != 16'hFFFF) sinceCs <= sinceCs + 16'd1;
      if (sclk) seenRise <= 1'b1;
    end
  end

  a_r5_sclk_low_when_deselected: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sclk);

  a_r5_cs_release_with_done: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csN) |-> done);

  a_r11_selected_implies_busy: assert property (@(posedge clk) disable iff (!rstN)
    !csN |-> busy);

  a_r11_done_ends_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));

  a_r11_start_drops_cs: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $fell(csN));

  a_r9_mosi_steady_while_high: assert property (@(posedge clk) disable iff (!rstN)
    (sclk && $past(sclk)) |-> $stable(mosi));

  a_r8_clock_parked_while_waiting: assert property (@(posedge clk) disable iff (!rstN)
    wrReady |-> (!sclk && !csN));

  a_r7_rx_strobe_inside_frame: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> busy);

  a_r10_setup_before_first_edge: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(sclk) && !seenRise) |-> (int'(sinceCs) >= HALF_DIV));

endmodule

bind spi_eeprom_seq spi_eeprom_seq_chk #(.HALF_DIV(HALF_DIV)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .busy    (busy),
  .done    (done),
  .csN     (csN),
  .sclk    (sclk),
  .mosi    (mosi),
  .wrReady (wrReady),
  .rdValid (rdValid)
);

// File: tb/spi_eeprom_seq_test.sv
`timescale 1ns/1ps
module spi_eeprom_seq_test;

  localparam int HALF_DIV = 2;
  localparam int ADDR_W   = 24;
  localparam int LEN_W    = 8;
  localparam int MAXB     = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [1:0] reqKind = '0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [LEN_W-1:0] reqLen = '0;
  logic busy, done, wrReady, rdValid, sclk, mosi, csN;
  logic [7:0] wrData = '0;
  logic wrValid = 1'b0;
  logic [7:0] rdData;
  logic miso = 1'b1;

  always #2 clk = ~clk;

  spi_eeprom_seq #(.HALF_DIV(HALF_DIV), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .reqAddr(reqAddr), .reqLen(reqLen), .busy(busy), .done(done),
    .wrData(wrData), .wrValid(wrValid), .wrReady(wrReady),
    .rdData(rdData), .rdValid(rdValid), .sclk(sclk), .mosi(mosi),
    .miso(miso), .csN(csN)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // transaction context
  logic [1:0]  curKind;
  logic [23:0] curAddr;
  int          curLen;
  logic [7:0]  wBytes [MAXB];
  logic [7:0]  sBytes [MAXB];   // slave reply per frame byte
  logic [7:0]  frame  [MAXB];
  logic [7:0]  rxGot  [MAXB];

  // monitor state
  int cyc = 0, rises = 0, bitsIn = 0, byteN = 0, rxN = 0;
  int csFalls = 0, csRises = 0, doneSeen = 0;
  int csFallCyc = 0, lastFallCyc = 0, firstGap = -1, holdGap = -1;
  int mosiBad = 0, waitBad = 0, slaveBit = 0, wrIdx = 0, wrWait = 0;
  logic [7:0] curByte = '0;
  logic prevCs = 1'b1, prevSclk = 1'b0, prevMosi = 1'b0, lastWrReady = 1'b0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic int hdrBytes(logic [1:0] k);
    return (k == 2'd2 || k == 2'd3) ? 4 : 1;
  endfunction

  function automatic int dataBytes(logic [1:0] k, int len);
    return (k == 2'd1) ? 0 : len;
  endfunction

  function automatic logic [7:0] expOpcode(logic [1:0] k);
    case (k)
      2'd0: return 8'h05;
      2'd1: return 8'h06;
      2'd2: return 8'h02;
      default: return 8'h03;
    endcase
  endfunction

  function automatic logic [7:0] expFrameByte(int idx);
    int h = hdrBytes(curKind);
    if (idx == 0) return expOpcode(curKind);
    if (idx < h)  return curAddr[8*(3-idx) +: 8];
    if (curKind == 2'd2) return wBytes[idx-h];
    return 8'hFF;
  endfunction

  function automatic logic misoBit(int k);
    if (k / 8 >= MAXB) return 1'b1;
    return sBytes[k/8][7 - (k % 8)];
  endfunction

  // bus monitor, slave model and write-data source, all on the falling clock edge
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (rstN) begin
        if (prevCs && !csN) begin
          csFalls++; csFallCyc = cyc; slaveBit = 0; miso = misoBit(0);
        end
        if (!prevCs && csN) begin
          csRises++; holdGap = cyc - lastFallCyc;
        end
        if (!prevSclk && sclk) begin
          rises++;
          if (firstGap < 0) firstGap = cyc - csFallCyc;
          curByte = {curByte[6:0], mosi};
          bitsIn++;
          if (bitsIn % 8 == 0 && byteN < MAXB) begin frame[byteN] = curByte; byteN++; end
        end
        if (prevSclk && !sclk) begin
          lastFallCyc = cyc; slaveBit++; miso = misoBit(slaveBit);
        end
        if (prevSclk && sclk && (mosi != prevMosi)) mosiBad++;
        if (wrReady && (sclk || csN)) waitBad++;
        if (rdValid && rxN < MAXB) begin rxGot[rxN] = rdData; rxN++; end
        if (done) doneSeen++;
        if (wrValid && lastWrReady) begin wrIdx++; wrValid = 1'b0; end
        if (wrReady && !wrValid) begin
          if (wrWait == 0) begin
            wrValid = 1'b1; wrData = wBytes[wrIdx]; wrWait = int'($urandom % 3);
          end else wrWait--;
        end
        lastWrReady = wrReady;
      end
      prevCs = csN; prevSclk = sclk; prevMosi = mosi;
    end
  end

  task automatic runTxn(input logic [1:0] k, input logic [23:0] a, input int len, input bit poke);
    int total, nData, wait_c;
    bit sawBusy, frameOk, rxOk;
    int badIdx;
    logic [7:0] badAct, badExp;
    curKind = k; curAddr = a; curLen = len;
    for (int i = 0; i < MAXB; i++) begin
      wBytes[i] = 8'($urandom); sBytes[i] = 8'($urandom);
    end
    rises = 0; bitsIn = 0; byteN = 0; rxN = 0; csFalls = 0; csRises = 0;
    doneSeen = 0; firstGap = -1; holdGap = -1; mosiBad = 0; waitBad = 0; wrIdx = 0;
    total = hdrBytes(k) + dataBytes(k, len);
    nData = dataBytes(k, len);
    @(negedge clk);
    reqValid = 1'b1; reqKind = k; reqAddr = a; reqLen = LEN_W'(len);
    @(negedge clk);
    reqValid = 1'b0;
    sawBusy = busy;
    if (poke) begin
      repeat (5) @(negedge clk);
      reqValid = 1'b1; reqKind = 2'd3; reqAddr = 24'hFFFFFF; reqLen = 8'd9;
      repeat (3) @(negedge clk);
      reqValid = 1'b0;
    end
    wait_c = 0;
    while (doneSeen == 0 && wait_c < 20000) begin @(negedge clk); wait_c++; end
    repeat (2) @(negedge clk);
    chk(sawBusy, "R11 busy after accept", longint'(sawBusy), 1);
    chk(doneSeen == 1 && !busy, "R11 single done then idle", doneSeen, 1);
    chk(rises == 8 * total, "R4 sclk rising edges", rises, 8 * total);
    chk(csFalls == 1 && csRises == 1, "R5 one cs fall and rise", csFalls * 16 + csRises, 17);
    frameOk = (byteN == total); badIdx = -1; badAct = 0; badExp = 0;
    for (int i = 0; i < total && i < byteN; i++) begin
      if (frame[i] !== expFrameByte(i) && badIdx < 0) begin
        badIdx = i; badAct = frame[i]; badExp = expFrameByte(i); frameOk = 0;
      end
    end
    if (k == 2'd2)
      chk(frameOk, $sformatf("R2 R3 R8 write frame byte %0d", badIdx), badAct, badExp);
    else if (k == 2'd3)
      chk(frameOk, $sformatf("R2 R3 R6 read frame byte %0d", badIdx), badAct, badExp);
    else
      chk(frameOk, $sformatf("R2 R6 short frame byte %0d", badIdx), badAct, badExp);
    if (k == 2'd2)
      chk(wrIdx == nData, "R8 write bytes consumed", wrIdx, nData);
    rxOk = 1; badAct = 0; badExp = 0;
    if (k == 2'd0 || k == 2'd3) begin
      chk(rxN == nData, "R7 received byte count", rxN, nData);
      for (int i = 0; i < nData && i < rxN; i++) begin
        if (rxGot[i] !== sBytes[hdrBytes(k) + i] && rxOk) begin
          rxOk = 0; badAct = rxGot[i]; badExp = sBytes[hdrBytes(k) + i];
        end
      end
      chk(rxOk, "R7 received byte values", badAct, badExp);
    end else begin
      chk(rxN == 0, "R7 no rdValid for write kinds", rxN, 0);
    end
    chk(firstGap >= HALF_DIV, "R10 cs setup before first edge", firstGap, HALF_DIV);
    chk(holdGap >= HALF_DIV, "R10 cs hold after last edge", holdGap, HALF_DIV);
    chk(mosiBad == 0, "R9 mosi stable while sclk high", mosiBad, 0);
    chk(waitBad == 0, "R8 clock parked during write wait", waitBad, 0);
    chk(csN && !sclk, "R5 idle bus after frame", {csN, sclk}, 2'b10);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    chk(csN === 1'b1 && sclk === 1'b0, "R1 reset bus idle", {csN, sclk}, 2'b10);
    chk(busy === 1'b0 && done === 1'b0, "R1 reset busy/done low", {busy, done}, 0);
    chk(rdValid === 1'b0 && wrReady === 1'b0, "R1 reset strobes low", {rdValid, wrReady}, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    runTxn(2'd0, 24'h000000, 1, 0);          // status, one byte
    runTxn(2'd1, 24'h123456, 5, 0);          // write enable, len ignored
    runTxn(2'd2, 24'hA53C0F, 3, 0);          // write
    runTxn(2'd3, 24'h010203, 4, 0);          // read
    runTxn(2'd3, 24'h800001, 0, 0);          // read with no data phase
    runTxn(2'd2, 24'h00FF00, 1, 1);          // request during busy is ignored
    for (int n = 0; n < 14; n++) begin
      runTxn(2'($urandom), 24'($urandom), int'($urandom % 7), bit'($urandom % 4 == 0));
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule